// File: doc/BRIEF.md
# Compressed Register ALU Executor

This block decodes and executes one 16-bit compressed instruction drawn from an encoding space whose meaning depends on the machine width. When the core runs in 32-bit mode, the encoding selects a small register-to-register ALU group. That group offers exclusive-or, three kinds of shift, and signed and unsigned set-less-than, all on the eight-register compressed subset. When the core runs in 64-bit mode, the same bits describe a doubleword store. Its address is a base register plus a scaled offset.

The core presents the instruction with a valid strobe, a mode bit, an extension-enable bit and the two source operand values. The block drives the two 3-bit source register fields straight back to the register file so that the operands can be read. One clock later it delivers exactly one of three outcomes: a register writeback, a store request, or an illegal-instruction indication.

Top module: `cq_alu_exec`

## Requirements
- R1: When `ext_en` is 0, every valid instruction produces `illegal`=1 one cycle later, with `wb_en`=0 and `st_req`=0, in either mode.
- R2: In 32-bit mode (`mode64`=0), `insn[12:10]` selects the function group and `insn[6:5]` the sub-operation. Group values 2, 4, 5, 6 and 7 are illegal.
- R3: In group 0, sub-op 0 writes rs1' XOR rs2' and sub-op 1 writes rs1' shifted right arithmetically, both to rs1'. Sub-ops 2 and 3 are illegal.
- R4: In group 1, sub-ops 0, 1, 2 and 3 compute the following, each written to rs1':
  - sub-op 0: logical left shift
  - sub-op 1: logical right shift
  - sub-op 2: signed set-less-than of rs1' against rs2'
  - sub-op 3: unsigned set-less-than of rs1' against rs2'
- R5: Group 3 computes the same four operations as group 1, but the result is written to rs2'.
- R6: Every shift uses only `rs2_val[4:0]` as its amount; higher bits of rs2' have no effect on the result.
- R7: In 32-bit mode the operation uses `rs1_val[31:0]` and `rs2_val[31:0]`, and `wb_data[63:32]` is 0. Set-less-than results are exactly 1 or 0.
- R8: In 64-bit mode (`mode64`=1, `ext_en`=1) the instruction is always a store. The outputs are:
  - `st_addr` = `rs1_val` + offset, where offset = {`insn[6:5]`, `insn[12:10]`, 3'b000}, zero-extended (0 to 248)
  - `st_data` = the full `rs2_val`
- R9: `rs1_idx` = `insn[9:7]` and `rs2_idx` = `insn[4:2]`, driven combinationally. `wb_idx` is the selected 3-bit field plus 8, giving a 5-bit architectural register number.
- R10: Outputs are registered. `out_valid` follows `in_valid` by one cycle, and at most one of `wb_en`, `st_req` and `illegal` is 1. All four are 0 after a cycle with `in_valid`=0, and all outputs are 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 16 | Compressed instruction bits |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| ext_en | input | 1 | Compressed extension enabled |
| rs1_val | input | 64 | Value of register rs1' |
| rs2_val | input | 64 | Value of register rs2' |
| rs1_idx | output | 3 | rs1' field for the register read |
| rs2_idx | output | 3 | rs2' field for the register read |
| out_valid | output | 1 | Registered result present |
| wb_en | output | 1 | Register writeback request |
| wb_idx | output | 5 | Architectural destination register |
| wb_data | output | 64 | Writeback value |
| st_req | output | 1 | Doubleword store request |
| st_addr | output | 64 | Store address |
| st_data | output | 64 | Store data |
| illegal | output | 1 | Illegal-instruction indication |

## Verification
The assertions take for granted that `rs1_val` and `rs2_val` already hold the registers named by `rs1_idx` and `rs2_idx` in the same cycle as the instruction. They also take for granted that `mode64` and `ext_en` are stable for the cycle in which they are sampled. The bench drives every input once per cycle on the falling edge and holds it through the following rising edge, so each capture sees a consistent set of inputs. Directed vectors cover the edges of the shift amount, the sign boundary of set-less-than, the largest store offset, and every group and sub-op code. Random cycles then mix the two modes, the enable and idle gaps.

// File: rtl/cq_alu_pkg.sv
// Package: shared types for the compressed register ALU executor.
// Assumes: the 32-bit ALU group and the 64-bit store share one decoder.
package cq_alu_pkg;

    localparam int OFF_W = 8;   // width of the scaled doubleword offset

    typedef enum logic [2:0] {
        OP_XOR  = 3'd0,
        OP_SRA  = 3'd1,
        OP_SLL  = 3'd2,
        OP_SRL  = 3'd3,
        OP_SLT  = 3'd4,
        OP_SLTU = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_STORE = 2'd1,
        K_ILL   = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        alu_op_e          op;
        logic             dst_rs2;
        logic [OFF_W-1:0] offset;
    } dec_t;

endpackage

// File: rtl/cq_decode.sv
// Module: cq_decode
// Turns the 16-bit instruction plus mode/enable into an action descriptor.
// Assumes: the instruction already lies in the shared ALU/store encoding space.
module cq_decode
    import cq_alu_pkg::*;
(
    input  logic [15:0] insn,
    input  logic        mode64,
    input  logic        ext_en,
    output dec_t        dec
);

    logic [2:0] group;
    logic [1:0] sub;

    assign group = insn[12:10];
    assign sub   = insn[6:5];

    // Purpose: select kind, operation, destination and offset.
    always_comb begin
        dec         = '0;
        dec.kind    = K_ILL;
        dec.op      = OP_XOR;
        dec.dst_rs2 = 1'b0;
        dec.offset  = {sub, group, 3'b000};
        if (!ext_en) begin
            dec.kind = K_ILL;
        end else if (mode64) begin
            dec.kind = K_STORE;
        end else begin
            unique case (group)
                3'd0: begin
                    unique case (sub)
                        2'd0:    begin dec.kind = K_ALU; dec.op = OP_XOR; end
                        2'd1:    begin dec.kind = K_ALU; dec.op = OP_SRA; end
                        default: dec.kind = K_ILL;
                    endcase
                end
                3'd1, 3'd3: begin
                    dec.kind    = K_ALU;
                    dec.dst_rs2 = (group == 3'd3);
                    unique case (sub)
                        2'd0:    dec.op = OP_SLL;
                        2'd1:    dec.op = OP_SRL;
                        2'd2:    dec.op = OP_SLT;
                        default: dec.op = OP_SLTU;
                    endcase
                end
                default: dec.kind = K_ILL;
            endcase
        end
    end

endmodule

// File: rtl/cq_alu.sv
// Module: cq_alu
// Narrow-width ALU for the 32-bit group: xor, shifts, set-less-than.
// Assumes: shift amount is the low log2(W) bits of operand b.
module cq_alu
    import cq_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    // Purpose: compute the selected operation.
    always_comb begin
        unique case (op)
            OP_XOR:  y = a ^ b;
            OP_SRA:  y = W'($signed(a) >>> shamt);
            OP_SLL:  y = a << shamt;
            OP_SRL:  y = a >> shamt;
            OP_SLT:  y = W'($signed(a) < $signed(b));
            OP_SLTU: y = W'(a < b);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/cq_agen.sv
// Module: cq_agen
// Store address generator: base register plus zero-extended scaled offset.
// Assumes: offset already carries its scaling (low bits zero).
module cq_agen #(
    parameter int AW = 64,
    parameter int OW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] offset,
    output logic [AW-1:0] addr
);

    // Purpose: add the zero-extended offset to the base.
    always_comb begin
        addr = base + AW'(offset);
    end

endmodule

// File: rtl/cq_alu_exec.sv
// Module: cq_alu_exec (top)
// Executes one compressed ALU-group or doubleword-store instruction per cycle
// and registers a single outcome: writeback, store, or illegal.
// Assumes: rs1_val/rs2_val are the registers named by rs1_idx/rs2_idx this cycle.
module cq_alu_exec
    import cq_alu_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int ALUW    = 32,
    parameter int REGBASE = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [15:0]     insn,
    input  logic            mode64,
    input  logic            ext_en,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic [2:0]      rs1_idx,
    output logic [2:0]      rs2_idx,
    output logic            out_valid,
    output logic            wb_en,
    output logic [4:0]      wb_idx,
    output logic [XLEN-1:0] wb_data,
    output logic            st_req,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data,
    output logic            illegal
);

    localparam int IDXW  = 3;
    localparam int AIDXW = 5;

    dec_t            dec;
    logic [ALUW-1:0] alu_y;
    logic [XLEN-1:0] agen_addr;
    logic [IDXW-1:0] dst_field;

    assign rs1_idx = insn[9:7];
    assign rs2_idx = insn[4:2];

    cq_decode u_dec (
        .insn   (insn),
        .mode64 (mode64),
        .ext_en (ext_en),
        .dec    (dec)
    );

    cq_alu #(.W(ALUW)) u_alu (
        .op (dec.op),
        .a  (rs1_val[ALUW-1:0]),
        .b  (rs2_val[ALUW-1:0]),
        .y  (alu_y)
    );

    cq_agen #(.AW(XLEN), .OW(OFF_W)) u_agen (
        .base   (rs1_val),
        .offset (dec.offset),
        .addr   (agen_addr)
    );

    // Purpose: choose which source field receives the ALU result.
    always_comb begin
        dst_field = dec.dst_rs2 ? rs2_idx : rs1_idx;
    end

    // Purpose: register exactly one outcome per valid instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_data   <= '0;
            st_req    <= 1'b0;
            st_addr   <= '0;
            st_data   <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= in_valid && (dec.kind == K_ALU);
            st_req    <= in_valid && (dec.kind == K_STORE);
            illegal   <= in_valid && (dec.kind == K_ILL);
            wb_idx    <= AIDXW'(REGBASE) + AIDXW'(dst_field);
            wb_data   <= (in_valid && dec.kind == K_ALU) ? XLEN'(alu_y) : '0;
            st_addr   <= (in_valid && dec.kind == K_STORE) ? agen_addr : '0;
            st_data   <= (in_valid && dec.kind == K_STORE) ? rs2_val : '0;
        end
    end

endmodule

// File: rtl/cq_alu_exec_chk.sv
// Module: cq_alu_exec_chk
// Assertion checker attached to cq_alu_exec through bind.
// Assumes: same port names and parameter as the top module.
module cq_alu_exec_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [15:0]     insn,
    input logic            mode64,
    input logic            ext_en,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic [2:0]      rs1_idx,
    input logic [2:0]      rs2_idx,
    input logic            out_valid,
    input logic            wb_en,
    input logic [4:0]      wb_idx,
    input logic [XLEN-1:0] wb_data,
    input logic            st_req,
    input logic [XLEN-1:0] st_addr,
    input logic [XLEN-1:0] st_data,
    input logic            illegal
);

    p_ext_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !ext_en |=> out_valid && illegal && !wb_en && !st_req);

    p_bad_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ext_en && !mode64 &&
        (insn[12:10] == 3'd2 || insn[12:10] >= 3'd4) |=> illegal);

    p_grp0_bad_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ext_en && !mode64 && insn[12:10] == 3'd0 && insn[6] |=> illegal);

    p_dst_rs2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ext_en && !mode64 && insn[12:10] == 3'd3
        |=> wb_en && wb_idx == {2'b01, $past(insn[4:2])});

    p_slt_bool_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ext_en && !mode64 && insn[6] &&
        (insn[12:10] == 3'd1 || insn[12:10] == 3'd3)
        |=> wb_en && wb_data[XLEN-1:1] == '0);

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_data[XLEN-1:32] == '0);

    p_store_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ext_en && mode64 |=> st_req && st_data == $past(rs2_val));

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, st_req, illegal}));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !wb_en && !st_req && !illegal);

    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid && (wb_en || st_req || illegal));

endmodule

bind cq_alu_exec cq_alu_exec_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/cq_alu_exec_tb.sv
// Bench: behavioural reference model compared on every clock.
module cq_alu_exec_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] insn;
    logic        mode64;
    logic        ext_en;
    logic [63:0] rs1_val;
    logic [63:0] rs2_val;
    logic [2:0]  rs1_idx;
    logic [2:0]  rs2_idx;
    logic        out_valid;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic        st_req;
    logic [63:0] st_addr;
    logic [63:0] st_data;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    // expected outcome of the instruction driven last
    logic        e_vld, e_wb, e_st, e_ill;
    logic [4:0]  e_idx;
    logic [63:0] e_data, e_addr, e_sdata;
    string       e_tag;

    always #10 clk = ~clk;   // 50 MHz

    cq_alu_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .mode64(mode64), .ext_en(ext_en), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .out_valid(out_valid),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .st_req(st_req),
        .st_addr(st_addr), .st_data(st_data), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // reference model, written from the requirements
    task automatic model(input bit v, input logic [15:0] i, input bit m64,
                         input bit en, input logic [63:0] a, input logic [63:0] b);
        int grp, sub, sh, r;
        logic [31:0] a32, b32, res;
        bit to_rs2;
        e_vld = v; e_wb = 0; e_st = 0; e_ill = 0;
        e_idx = 0; e_data = 0; e_addr = 0; e_sdata = 0; e_tag = "R10";
        if (!v) return;
        grp = int'(i[12:10]); sub = int'(i[6:5]);
        a32 = a[31:0]; b32 = b[31:0]; sh = int'(b[4:0]);
        if (!en) begin e_ill = 1; e_tag = "R1"; return; end
        if (m64) begin
            e_st = 1; e_tag = "R8";
            e_addr = a + 64'(sub * 64 + grp * 8);
            e_sdata = b;
            return;
        end
        to_rs2 = (grp == 3);
        r = (grp == 0) ? 0 : ((grp == 1 || grp == 3) ? 1 : -1);
        if (r < 0 || (r == 0 && sub >= 2)) begin
            e_ill = 1; e_tag = (r < 0) ? "R2" : "R3";
            return;
        end
        if (r == 0) res = (sub == 0) ? (a32 ^ b32) : 32'($signed(a32) >>> sh);
        else case (sub)
            0: res = a32 << sh;
            1: res = a32 >> sh;
            2: res = ($signed(a32) < $signed(b32)) ? 32'd1 : 32'd0;
            default: res = (a32 < b32) ? 32'd1 : 32'd0;
        endcase
        e_wb = 1;
        e_data = {32'd0, res};
        e_idx = 5'(8 + int'(to_rs2 ? i[4:2] : i[9:7]));
        e_tag = to_rs2 ? "R5" : ((r == 0) ? "R3" : "R4");
    endtask

    task automatic compare();
        chk(out_valid == e_vld, "R10", "out_valid", 64'(out_valid), 64'(e_vld));
        chk(illegal == e_ill, e_tag, "illegal", 64'(illegal), 64'(e_ill));
        chk(wb_en == e_wb, e_tag, "wb_en", 64'(wb_en), 64'(e_wb));
        chk(st_req == e_st, e_tag, "st_req", 64'(st_req), 64'(e_st));
        if (e_wb) begin
            chk(wb_idx == e_idx, e_tag, "wb_idx (R9)", 64'(wb_idx), 64'(e_idx));
            chk(wb_data == e_data, e_tag, "wb_data (R6 R7)", wb_data, e_data);
        end
        if (e_st) begin
            chk(st_addr == e_addr, "R8", "st_addr", st_addr, e_addr);
            chk(st_data == e_sdata, "R8", "st_data", st_data, e_sdata);
        end
    endtask

    // drive on the falling edge, compare at the next falling edge
    task automatic step(input bit v, input logic [15:0] i, input bit m64,
                        input bit en, input logic [63:0] a, input logic [63:0] b);
        in_valid = v; insn = i; mode64 = m64; ext_en = en; rs1_val = a; rs2_val = b;
        #1;
        chk(rs1_idx == i[9:7], "R9", "rs1_idx", 64'(rs1_idx), 64'(i[9:7]));
        chk(rs2_idx == i[4:2], "R9", "rs2_idx", 64'(rs2_idx), 64'(i[4:2]));
        model(v, i, m64, en, a, b);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [15:0] mk(int grp, int sub, int f1, int f2);
        return {3'b100, 3'(grp), 3'(f1), 2'(sub), 3'(f2), 2'b01};
    endfunction

    initial begin
        rst_n = 0; in_valid = 1; insn = mk(0, 0, 1, 2); mode64 = 0; ext_en = 1;
        rs1_val = '1; rs2_val = '1;
        repeat (3) @(negedge clk);
        chk(!out_valid && !wb_en && !st_req && !illegal && wb_data == 0,
            "R10", "reset state", {60'd0, out_valid, wb_en, st_req, illegal}, 64'd0);
        rst_n = 1;
        in_valid = 0;
        @(negedge clk);
        // R3 xor and arithmetic shift, R6 amount 33 acts as 1
        step(1, mk(0, 0, 3, 5), 0, 1, 64'hFFFF_0000_1234_5678, 64'h0000_FFFF_0F0F_0F0F);
        step(1, mk(0, 1, 7, 0), 0, 1, 64'h0000_0000_8000_0010, 64'hFFFF_FFFF_0000_0021);
        step(1, mk(0, 1, 7, 0), 0, 1, 64'h0000_0000_8000_0000, 64'd31);
        step(1, mk(0, 2, 1, 1), 0, 1, 64'd5, 64'd6);     // R3 sub-op 2 illegal
        step(1, mk(0, 3, 1, 1), 0, 1, 64'd5, 64'd6);     // R3 sub-op 3 illegal
        // R4 group 1 all sub-ops
        step(1, mk(1, 0, 2, 4), 0, 1, 64'h0000_0000_8000_0001, 64'd31);
        step(1, mk(1, 1, 2, 4), 0, 1, 64'h0000_0000_8000_0000, 64'h0000_0100_0000_001F);
        step(1, mk(1, 2, 2, 4), 0, 1, 64'h0000_0000_8000_0000, 64'd1);
        step(1, mk(1, 3, 2, 4), 0, 1, 64'h0000_0000_8000_0000, 64'd1);
        step(1, mk(1, 2, 2, 4), 0, 1, 64'd3, 64'd3);
        // R5 group 3 writes rs2'
        step(1, mk(3, 0, 6, 1), 0, 1, 64'd1, 64'd4);
        step(1, mk(3, 3, 6, 1), 0, 1, 64'd2, 64'hFFFF_FFFF);
        step(1, mk(3, 2, 0, 7), 0, 1, 64'hFFFF_FFFF, 64'd0);
        // R2 illegal groups
        for (int g = 2; g < 8; g++) if (g != 3) step(1, mk(g, 0, 1, 2), 0, 1, 64'd9, 64'd9);
        // R1 extension off, both modes
        step(1, mk(1, 0, 1, 2), 0, 0, 64'd9, 64'd9);
        step(1, mk(1, 0, 1, 2), 1, 0, 64'd9, 64'd9);
        // R8 store, offsets 0 and 248
        step(1, mk(0, 0, 4, 5), 1, 1, 64'h1000, 64'hDEAD_BEEF_CAFE_F00D);
        step(1, mk(7, 3, 4, 5), 1, 1, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0123_4567_89AB_CDEF);
        step(1, mk(2, 1, 0, 0), 1, 1, 64'h8000_0000_0000_0000, 64'd7);
        // R10 idle gap
        step(0, mk(1, 0, 1, 2), 0, 1, 64'd1, 64'd1);
        step(0, mk(1, 0, 1, 2), 1, 1, 64'd1, 64'd1);
        // random mix
        for (int n = 0; n < 2000; n++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom}; b = {$urandom, $urandom};
            if (n % 7 == 0) b[31:0] = a[31:0];
            step(($urandom % 8) != 0, 16'($urandom), 1'($urandom),
                 ($urandom % 10) != 0, a, b);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule